// File: doc/BRIEF.md
# Addend-Trimmed System Time Counter

This block keeps a free-running 64-bit system time for a precision time protocol endpoint. Its tick rate is not fixed by the reference clock. Every reference clock adds a 32-bit rate word into a 32-bit fractional accumulator. Each carry out of that sum advances the time by one unit of 32 ns. Software trims the frequency by nudging the rate word up or down from its nominal value of 0xA0000000. The counter is exposed as a low word and a high word. A programmable limit sets the value at which the low word rolls over into the high word.

Access goes through a small word-wide register bus. A read returns its data on the clock after the read strobe. Reading the low time word captures the high word in a shadow, so a following high read returns the matching half. Writing the low word only stages it. The high write then loads all 64 bits in one clock. The limit register can only be written while a separate unlock register holds 1. Bit 0 of the control register holds the whole block in soft reset for as long as it is set.

Two small state machines drive the block. The block machine has state RUN and state HOLD. It goes RUN to HOLD on a control write with bit 0 set, and HOLD to RUN on a control write with bit 0 clear. The load machine has state IDLE and state STAGED. It goes IDLE to STAGED on a low-word write, and STAGED to IDLE on a high-word write. While the block machine is in HOLD, the load machine is forced to IDLE.

Top module: `trim_time_counter`

## Requirements
- R1: After reset the time is 0. Reads return 0 for control, 0xA0000000 for rate, 0xFFFFFFFF for limit and 0 for unlock.
- R2: Each clock outside HOLD sets accumulator = (accumulator + rate) mod 2^32. The time advances by exactly one only in a clock whose sum carries out. With rate 0 the time does not move.
- R3: On an advancing clock, the low word goes to 0 and the high word increments when the low word equals the limit or equals 0xFFFFFFFF. Otherwise the low word increments.
- R4: The register map is: address 0 control (bit 0 hold), 1 rate, 2 time low, 3 time high, 4 unlock (bit 0), 5 limit. Reading address 2 returns the current low word and copies the current high word into a shadow. Reading address 3 returns the shadow. `bus_rdata` updates on the clock that samples `bus_rd` and holds its value otherwise.
- R5: A write to address 2 stages a low word (IDLE to STAGED). A later write to address 3 in STAGED loads {written high, staged low} into the time in that clock, in place of any advance, and returns to IDLE. The accumulator is not disturbed.
- R6: A write to address 3 in IDLE is ignored, and the time keeps counting.
- R7: A write to address 5 changes the limit only while the unlock bit is 1. Otherwise the limit keeps its value.
- R8: Writing control bit 0 = 1 enters HOLD from the next clock. In HOLD every clock clears the time and the accumulator, restores the rate, limit and unlock to their reset values, ignores every write except to control, and keeps serving reads. Writing bit 0 = 0 returns to RUN.
- R9: Reads of addresses 6 and 7 return 0. Writes to them have no effect.
- R10: A new rate is used for the accumulation starting with the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after `bus_rd` |
| time_now | output | 64 | Current system time in 32 ns units |

## Verification
The bench targets the low-word rollover in three ways: at a lowered limit, at all ones while the limit sits below the low word, and for a high-word read taken after a rollover. If the rollover were handled wrongly, the high word would skip, the low word would run past the limit, or the high read would disagree with the low read. It issues a high write without a staged low word, which a careless loader would accept as a partial load. It also issues a locked limit write and writes made during HOLD. A design that ignored the unlock or hold gating would change a readback value. The bench sweeps rate values of 0, all ones and nominal, because an off-by-one in the carry shows up as drift against the reference model within a few clocks.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_RATE = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_TLO  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_THI  = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_ULK  = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_LIM  = 3'd5;

    typedef enum logic {
        BLK_RUN,
        BLK_HOLD
    } blk_state_t;

    typedef enum logic {
        LD_IDLE,
        LD_STAGED
    } ld_state_t;
endpackage

// File: rtl/ttc_accum.sv
module ttc_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [ACC_W-1:0] rate,
    output logic             carry
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    assign sum   = {1'b0, acc_q} + {1'b0, rate};
    assign carry = sum[ACC_W] & ~clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else begin
            acc_q <= sum[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/ttc_time_core.sv
module ttc_time_core #(
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                tick,
    input  logic                load,
    input  logic [2*WORD_W-1:0] load_val,
    input  logic [WORD_W-1:0]   limit,
    output logic [2*WORD_W-1:0] now
);
    logic [WORD_W-1:0] lo_q;
    logic [WORD_W-1:0] hi_q;
    logic              roll;

    assign roll = (lo_q == limit) || (lo_q == {WORD_W{1'b1}});
    assign now  = {hi_q, lo_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (clear) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (load) begin
            lo_q <= load_val[WORD_W-1:0];
            hi_q <= load_val[2*WORD_W-1:WORD_W];
        end else if (tick) begin
            if (roll) begin
                lo_q <= '0;
                hi_q <= hi_q + 1'b1;
            end else begin
                lo_q <= lo_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ttc_regs.sv
module ttc_regs
    import ttc_pkg::*;
#(
    parameter int                WORD_W   = 32,
    parameter logic [WORD_W-1:0] DEF_RATE = 32'hA000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    input  logic [2*WORD_W-1:0] time_now,
    output logic [WORD_W-1:0]   rdata,
    output logic [WORD_W-1:0]   rate,
    output logic [WORD_W-1:0]   limit,
    output logic                unlock,
    output logic                hold,
    output logic                load,
    output logic [2*WORD_W-1:0] load_val
);
    blk_state_t blk_q, blk_d;
    ld_state_t  ld_q, ld_d;

    logic [WORD_W-1:0] staged_lo_q;
    logic [WORD_W-1:0] shadow_q;
    logic [WORD_W-1:0] rd_mux;
    logic wr_ctrl, wr_rate, wr_lo, wr_hi, wr_ulk, wr_lim, rd_lo;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_rate = bus_wr && (bus_addr == ADDR_RATE);
    assign wr_lo   = bus_wr && (bus_addr == ADDR_TLO);
    assign wr_hi   = bus_wr && (bus_addr == ADDR_THI);
    assign wr_ulk  = bus_wr && (bus_addr == ADDR_ULK);
    assign wr_lim  = bus_wr && (bus_addr == ADDR_LIM);
    assign rd_lo   = bus_rd && (bus_addr == ADDR_TLO);

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q <= BLK_RUN;
            ld_q  <= LD_IDLE;
        end else begin
            blk_q <= blk_d;
            ld_q  <= ld_d;
        end
    end

    // next-state logic
    always_comb begin
        blk_d = blk_q;
        unique case (blk_q)
            BLK_RUN:  if (wr_ctrl && bus_wdata[0])  blk_d = BLK_HOLD;
            BLK_HOLD: if (wr_ctrl && !bus_wdata[0]) blk_d = BLK_RUN;
        endcase
        ld_d = ld_q;
        if (blk_q == BLK_HOLD) begin
            ld_d = LD_IDLE;
        end else begin
            unique case (ld_q)
                LD_IDLE:   if (wr_lo) ld_d = LD_STAGED;
                LD_STAGED: if (wr_hi) ld_d = LD_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        hold     = (blk_q == BLK_HOLD);
        load     = !hold && wr_hi && (ld_q == LD_STAGED);
        load_val = {bus_wdata, staged_lo_q};
    end

    // software-visible registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate        <= DEF_RATE;
            limit       <= '1;
            unlock      <= 1'b0;
            staged_lo_q <= '0;
            shadow_q    <= '0;
        end else if (hold) begin
            rate        <= DEF_RATE;
            limit       <= '1;
            unlock      <= 1'b0;
            staged_lo_q <= '0;
            shadow_q    <= '0;
        end else begin
            if (wr_rate)           rate        <= bus_wdata;
            if (wr_ulk)            unlock      <= bus_wdata[0];
            if (wr_lim && unlock)  limit       <= bus_wdata;
            if (wr_lo)             staged_lo_q <= bus_wdata;
            if (rd_lo)             shadow_q    <= time_now[2*WORD_W-1:WORD_W];
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL: rd_mux = {{(WORD_W-1){1'b0}}, hold};
            ADDR_RATE: rd_mux = rate;
            ADDR_TLO:  rd_mux = time_now[WORD_W-1:0];
            ADDR_THI:  rd_mux = shadow_q;
            ADDR_ULK:  rd_mux = {{(WORD_W-1){1'b0}}, unlock};
            ADDR_LIM:  rd_mux = limit;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (bus_rd) begin
            rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/trim_time_counter.sv
module trim_time_counter
    import ttc_pkg::*;
#(
    parameter int                WORD_W   = 32,
    parameter logic [WORD_W-1:0] DEF_RATE = 32'hA000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic [2*WORD_W-1:0] time_now
);
    localparam int TIME_W = 2 * WORD_W;

    logic [WORD_W-1:0] rate_q;
    logic [WORD_W-1:0] limit_q;
    logic              limit_en_q;
    logic              hold_q;
    logic              load_now;
    logic [TIME_W-1:0] load_word;
    logic              acc_carry;

    ttc_regs #(.WORD_W(WORD_W), .DEF_RATE(DEF_RATE)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .time_now (time_now),
        .rdata    (bus_rdata),
        .rate     (rate_q),
        .limit    (limit_q),
        .unlock   (limit_en_q),
        .hold     (hold_q),
        .load     (load_now),
        .load_val (load_word)
    );

    ttc_accum #(.ACC_W(WORD_W)) u_accum (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(hold_q),
        .rate (rate_q),
        .carry(acc_carry)
    );

    ttc_time_core #(.WORD_W(WORD_W)) u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (hold_q),
        .tick    (acc_carry),
        .load    (load_now),
        .load_val(load_word),
        .limit   (limit_q),
        .now     (time_now)
    );
endmodule

// File: rtl/trim_time_counter_chk.sv
module trim_time_counter_chk
    import ttc_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [2*WORD_W-1:0] time_now,
    input logic                hold,
    input logic                carry,
    input logic [WORD_W-1:0]   limit,
    input logic                limit_en
);
    logic hi_wr;
    logic lim_wr;
    assign hi_wr  = bus_wr && (bus_addr == ADDR_THI);
    assign lim_wr = bus_wr && (bus_addr == ADDR_LIM);

    p_hold_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (time_now == '0));

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !carry && !hi_wr) |=> $stable(time_now));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && carry && !hi_wr && (time_now[WORD_W-1:0] != limit)
         && (time_now[WORD_W-1:0] != {WORD_W{1'b1}}))
        |=> (time_now == $past(time_now) + 1'b1));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && carry && !hi_wr && (time_now[WORD_W-1:0] == limit))
        |=> ((time_now[WORD_W-1:0] == '0)
             && (time_now[2*WORD_W-1:WORD_W] == $past(time_now[2*WORD_W-1:WORD_W]) + 1'b1)));

    p_limit_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !limit_en && lim_wr) |=> $stable(limit));
endmodule

bind trim_time_counter trim_time_counter_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .time_now(time_now),
    .hold    (hold_q),
    .carry   (acc_carry),
    .limit   (limit_q),
    .limit_en(limit_en_q)
);

// File: tb/tb_trim_time_counter.sv
`timescale 1ns/1ps
module tb_trim_time_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] time_now;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    trim_time_counter dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .time_now(time_now)
    );

    // behavioural reference model
    logic [31:0] m_acc, m_rate, m_lo, m_hi, m_lim, m_slo, m_sh, m_rd;
    logic        m_en, m_hold, m_stg;
    logic [32:0] m_sum;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_acc = 0; m_rate = 32'hA000_0000; m_lo = 0; m_hi = 0;
            m_lim = 32'hFFFF_FFFF; m_slo = 0; m_sh = 0; m_rd = 0;
            m_en = 0; m_hold = 0; m_stg = 0;
        end else begin
            if (bus_rd) begin
                case (bus_addr)
                    3'd0: m_rd = {31'b0, m_hold};
                    3'd1: m_rd = m_rate;
                    3'd2: m_rd = m_lo;
                    3'd3: m_rd = m_sh;
                    3'd4: m_rd = {31'b0, m_en};
                    3'd5: m_rd = m_lim;
                    default: m_rd = 0;
                endcase
            end
            if (m_hold) begin
                m_acc = 0; m_lo = 0; m_hi = 0; m_rate = 32'hA000_0000;
                m_lim = 32'hFFFF_FFFF; m_en = 0; m_stg = 0; m_slo = 0; m_sh = 0;
                if (bus_wr && bus_addr == 3'd0) m_hold = bus_wdata[0];
            end else begin
                if (bus_rd && bus_addr == 3'd2) m_sh = m_hi;
                m_sum = {1'b0, m_acc} + {1'b0, m_rate};
                m_acc = m_sum[31:0];
                if (bus_wr && bus_addr == 3'd3 && m_stg) begin
                    m_hi = bus_wdata; m_lo = m_slo; m_stg = 0;
                end else if (m_sum[32]) begin
                    if (m_lo == m_lim || m_lo == 32'hFFFF_FFFF) begin
                        m_lo = 0; m_hi = m_hi + 1;
                    end else begin
                        m_lo = m_lo + 1;
                    end
                end
                if (bus_wr) begin
                    case (bus_addr)
                        3'd0: m_hold = bus_wdata[0];
                        3'd1: m_rate = bus_wdata;
                        3'd2: begin m_slo = bus_wdata; m_stg = 1; end
                        3'd4: m_en = bus_wdata[0];
                        3'd5: if (m_en) m_lim = bus_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            n_cmp++;
            if (time_now !== {m_hi, m_lo}) begin
                n_bad++;
                $display("FAIL %s time_now actual=%h expected=%h", cur_req, time_now, {m_hi, m_lo});
            end
            n_cmp++;
            if (bus_rdata !== m_rd) begin
                n_bad++;
                $display("FAIL %s bus_rdata actual=%h expected=%h", cur_req, bus_rdata, m_rd);
            end
        end
    end

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        rd(a);
        @(negedge clk);
        check(req, {32'b0, bus_rdata}, {32'b0, exp});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [63:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";
        check("R1", time_now, 64'h0);
        rd_chk("R1", 3'd1, 32'hA000_0000);
        rd_chk("R1", 3'd5, 32'hFFFF_FFFF);
        rd_chk("R1", 3'd4, 32'h0);
        rd_chk("R1", 3'd0, 32'h0);

        cur_req = "R2";
        idle(40);
        cur_req = "R10";
        wr(3'd1, 32'hFFFF_FFFF);
        idle(20);
        wr(3'd1, 32'h1000_0000);
        idle(40);
        cur_req = "R2";
        wr(3'd1, 32'h0);
        @(negedge clk);
        snap = time_now;
        idle(20);
        check("R2", time_now, snap);

        cur_req = "R5";
        wr(3'd1, 32'h1000_0000);
        wr(3'd2, 32'h0000_0100);
        wr(3'd3, 32'h0000_0007);
        @(negedge clk);
        check("R5", time_now, 64'h0000_0007_0000_0100);
        idle(10);

        cur_req = "R4";
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd2, 32'hFFFF_FFF0);
        wr(3'd3, 32'h0000_0002);
        rd(3'd2);
        idle(30);
        rd_chk("R4", 3'd3, 32'h0000_0002);

        cur_req = "R6";
        wr(3'd3, 32'h0000_0055);
        @(negedge clk);
        check("R6", {32'b0, time_now[63:32]}, 64'h3);
        idle(5);

        cur_req = "R7";
        wr(3'd5, 32'h0000_000A);
        rd_chk("R7", 3'd5, 32'hFFFF_FFFF);
        wr(3'd4, 32'h1);
        wr(3'd5, 32'h0000_0020);
        wr(3'd4, 32'h0);
        rd_chk("R7", 3'd5, 32'h0000_0020);

        cur_req = "R3";
        wr(3'd2, 32'h0000_001C);
        wr(3'd3, 32'h0000_0009);
        idle(12);
        check("R3", {32'b0, time_now[63:32]}, 64'hA);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'h0000_0040);
        idle(5);
        check("R3", {32'b0, time_now[63:32]}, 64'h41);

        cur_req = "R8";
        wr(3'd1, 32'h1234_5678);
        wr(3'd0, 32'h1);
        idle(2);
        check("R8", time_now, 64'h0);
        wr(3'd1, 32'h5);
        rd_chk("R8", 3'd1, 32'hA000_0000);
        rd_chk("R8", 3'd0, 32'h1);
        rd_chk("R8", 3'd5, 32'hFFFF_FFFF);
        wr(3'd0, 32'h0);
        idle(20);

        cur_req = "R9";
        rd_chk("R9", 3'd7, 32'h0);
        wr(3'd6, 32'hDEAD_BEEF);
        rd_chk("R9", 3'd6, 32'h0);
        rd_chk("R9", 3'd1, 32'hA000_0000);

        cur_req = "R4";
        for (int i = 0; i < 300; i++) begin
            int op;
            op = $urandom % 8;
            if (op < 3)       rd($urandom % 8);
            else if (op == 3) wr(3'd1, 32'h8000_0000 + ($urandom % 32'h4000_0000));
            else if (op == 4) wr(3'd2, $urandom);
            else if (op == 5) wr(3'd3, $urandom % 16);
            else if (op == 6) wr(3'd4, $urandom % 2);
            else              wr(3'd5, $urandom % 64);
        end
        idle(10);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule